// File: doc/BRIEF.md
# Comma Search and Symbol Boundary Aligner

This block sits behind a deserializer that delivers 10-bit words whose symbol boundaries are unknown. It joins each incoming word with the one before it into a sliding window. It looks at every one of the ten possible bit offsets in that window for either comma polarity. When a comma turns up whose polarity is enabled, the block moves its symbol boundary to that offset. A barrel shifter then cuts realigned 10-bit symbols out of the window at the stored offset. Bit 0 of each word is the earliest bit on the line.

Three status outputs report what the search finds:
- `comma_seen` is raised whenever a comma of either polarity is found.
- `realigned` is a one-cycle pulse that fires only when the stored boundary actually moves.
- `locked` is raised once the stream sits on a boundary set by an enabled comma.

Each polarity has its own realignment enable. Parameters decide which polarities may raise `locked`. Driving `use_align` low bypasses the whole search. Words then go straight to a single output register, which cuts the latency from three cycles to one. The comma flag comes out two cycles ahead of the aligned comma symbol, so downstream logic can prepare for it. Words in the pipeline while the boundary moves may come out corrupted.

Top module: `comma_aligner`

## Requirements
- R1: With `use_align`=1, `comma_seen` is 1 right after a clock edge exactly when, at that edge, the window {rx_word[8:0], previous rx_word} held a plus comma at some offset k in 0..9. A plus comma is window bits [k+6:k] equal to 7'b1111100, meaning two 0s followed by five 1s in line order.
- R2: The same rule applies to a minus comma, which is window bits [k+6:k] equal to 7'b0000011 (two 1s followed by five 0s).
- R3: A plus comma moves the stored offset only while `plus_align_en`=1. Otherwise the offset is unchanged and `realigned` stays 0.
- R4: A minus comma moves the stored offset only while `minus_align_en`=1. Otherwise the offset is unchanged and `realigned` stays 0.
- R5: `realigned` is 1 for exactly one cycle when an enabled comma is found at an offset other than the stored one. It stays 0 when the enabled comma is at the stored offset.
- R6: When enabled commas are found at several offsets in the same window, the lowest offset is chosen.
- R7: In use mode, `aligned_word` shows window bits [off+9:off] two clock edges after the edge that captured that window. Here off is the offset stored at that edge. A comma symbol therefore appears two cycles after its `comma_seen`.
- R8: `locked` goes to 1 at the first enabled comma whose polarity has its lock parameter set (both are set by default). It then holds, and it clears while `use_align`=0.
- R9: With `use_align`=0, `aligned_word` equals the word captured at the previous edge. `comma_seen` and `realigned` stay 0, and the stored offset is held for the return to use mode.
- R10: Synchronous active-high `rst` clears the stored offset to 0. It also forces `aligned_word`, `comma_seen`, `realigned` and `locked` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_word | input | 10 | Raw deserialized word, bit 0 earliest |
| use_align | input | 1 | 1: search and align, 0: low-latency bypass |
| plus_align_en | input | 1 | Allow plus commas to move the boundary |
| minus_align_en | input | 1 | Allow minus commas to move the boundary |
| aligned_word | output | 10 | Realigned (or bypassed) symbol |
| comma_seen | output | 1 | A comma of either polarity was found |
| realigned | output | 1 | One-cycle pulse on a boundary move |
| locked | output | 1 | Stream sits on a comma-set boundary |

## Verification
The hardest case to reach from the ports is a single window that holds two enabled commas at different offsets. Random data almost never produces one that the bench can recognise. The bench builds such a window by hand: a plus comma at offset 0 and a minus comma at offset 8, packed into one pair of words. It first moves the boundary to offset 5, so that choosing the lower offset shows up both in `realigned` and in the extracted symbol. Filler is an alternating bit pattern, which can never contain five equal bits in a row. As a result, only the comma the bench places can match anywhere in the window.

// File: rtl/cad_pkg.sv
package cad_pkg;
  // default symbol geometry
  localparam int unsigned CAD_SYM_W   = 10;
  localparam int unsigned CAD_COMMA_W = 7;
  // comma patterns as bit vectors, bit 0 earliest on the line
  localparam logic [CAD_COMMA_W-1:0] CAD_PLUS_PAT  = 7'b1111100;
  localparam logic [CAD_COMMA_W-1:0] CAD_MINUS_PAT = 7'b0000011;

  // width of an offset able to address n positions
  function automatic int unsigned cad_off_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cad_window.sv
module cad_window #(
  parameter int unsigned SYM_W = 10,
  localparam int unsigned WIN_W = 2*SYM_W-1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] rx_word,
  output logic [WIN_W-1:0] win
);
  logic [SYM_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= rx_word;
  end

  // older word sits in the low bits; the top bit of the newest word
  // can never start a symbol at offsets 0..SYM_W-1 and is left out
  assign win = {rx_word[SYM_W-2:0], prev_q};
endmodule

// File: rtl/cad_scan.sv
module cad_scan #(
  parameter int unsigned SYM_W   = 10,
  parameter int unsigned COMMA_W = 7,
  parameter logic [COMMA_W-1:0] PLUS_PAT  = 7'b1111100,
  parameter logic [COMMA_W-1:0] MINUS_PAT = 7'b0000011,
  localparam int unsigned SCAN_W = SYM_W + COMMA_W - 1
) (
  input  logic [SCAN_W-1:0] win,
  output logic [SYM_W-1:0]  plus_hit,
  output logic [SYM_W-1:0]  minus_hit
);
  // one comparator pair per candidate offset
  for (genvar k = 0; k < SYM_W; k++) begin : g_off
    assign plus_hit[k]  = (win[k +: COMMA_W] == PLUS_PAT);
    assign minus_hit[k] = (win[k +: COMMA_W] == MINUS_PAT);
  end
endmodule

// File: rtl/cad_offset_ctl.sv
module cad_offset_ctl #(
  parameter int unsigned SYM_W = 10,
  parameter bit LOCK_ON_PLUS  = 1'b1,
  parameter bit LOCK_ON_MINUS = 1'b1,
  localparam int unsigned OFF_W = cad_pkg::cad_off_bits(SYM_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_align,
  input  logic             plus_en,
  input  logic             minus_en,
  input  logic [SYM_W-1:0] plus_hit,
  input  logic [SYM_W-1:0] minus_hit,
  output logic [OFF_W-1:0] off_q,
  output logic             en_hit_any,
  output logic             comma_seen,
  output logic             realigned,
  output logic             locked
);
  logic [SYM_W-1:0] cand;
  logic [OFF_W-1:0] hit_off;
  logic             any_comma;
  logic             lock_hit;
  logic             move;

  assign cand = use_align ? ((plus_hit  & {SYM_W{plus_en}}) |
                             (minus_hit & {SYM_W{minus_en}})) : '0;
  assign en_hit_any = |cand;
  assign any_comma  = use_align && ((|plus_hit) || (|minus_hit));
  assign lock_hit   = use_align &&
                      ((LOCK_ON_PLUS  && plus_en  && (|plus_hit)) ||
                       (LOCK_ON_MINUS && minus_en && (|minus_hit)));

  // lowest enabled offset wins: scan downward, last assignment sticks
  always_comb begin
    hit_off = '0;
    for (int i = SYM_W-1; i >= 0; i--) begin
      if (cand[i]) hit_off = OFF_W'(i);
    end
  end

  assign move = en_hit_any && (hit_off != off_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q      <= '0;
      comma_seen <= 1'b0;
      realigned  <= 1'b0;
      locked     <= 1'b0;
    end else begin
      comma_seen <= any_comma;
      realigned  <= move;
      if (move) off_q <= hit_off;
      if (!use_align)    locked <= 1'b0;
      else if (lock_hit) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/cad_shift.sv
module cad_shift #(
  parameter int unsigned SYM_W = 10,
  localparam int unsigned WIN_W = 2*SYM_W-1,
  localparam int unsigned OFF_W = cad_pkg::cad_off_bits(SYM_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_align,
  input  logic [SYM_W-1:0] rx_word,
  input  logic [WIN_W-1:0] win,
  input  logic [OFF_W-1:0] off_q,
  output logic [SYM_W-1:0] aligned_word
);
  logic [WIN_W-1:0] win_q;
  logic [SYM_W-1:0] slices [SYM_W];
  logic [SYM_W-1:0] sh_d, sh_q;

  for (genvar k = 0; k < SYM_W; k++) begin : g_slice
    assign slices[k] = win_q[k +: SYM_W];
  end

  always_comb begin
    sh_d = '0;
    for (int i = 0; i < SYM_W; i++) begin
      if (off_q == OFF_W'(i)) sh_d = slices[i];
    end
  end

  // stage 1: window, stage 2: barrel, stage 3: output (bypass enters here)
  always_ff @(posedge clk) begin
    if (rst) begin
      win_q        <= '0;
      sh_q         <= '0;
      aligned_word <= '0;
    end else begin
      win_q        <= win;
      sh_q         <= sh_d;
      aligned_word <= use_align ? sh_q : rx_word;
    end
  end
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
  import cad_pkg::*;
#(
  parameter int unsigned SYM_W   = CAD_SYM_W,
  parameter int unsigned COMMA_W = CAD_COMMA_W,
  parameter logic [COMMA_W-1:0] PLUS_PAT  = CAD_PLUS_PAT,
  parameter logic [COMMA_W-1:0] MINUS_PAT = CAD_MINUS_PAT,
  parameter bit LOCK_ON_PLUS  = 1'b1,
  parameter bit LOCK_ON_MINUS = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] rx_word,
  input  logic             use_align,
  input  logic             plus_align_en,
  input  logic             minus_align_en,
  output logic [SYM_W-1:0] aligned_word,
  output logic             comma_seen,
  output logic             realigned,
  output logic             locked
);
  localparam int unsigned OFF_W  = cad_off_bits(SYM_W);
  localparam int unsigned WIN_W  = 2*SYM_W-1;
  localparam int unsigned SCAN_W = SYM_W + COMMA_W - 1;

  // internal events, named for the checker
  logic [WIN_W-1:0] win;
  logic [SYM_W-1:0] plus_hit, minus_hit;
  logic [OFF_W-1:0] off_q;
  logic             en_hit_any;

  cad_window #(.SYM_W(SYM_W)) u_window (
    .clk(clk), .rst(rst), .rx_word(rx_word), .win(win)
  );

  cad_scan #(
    .SYM_W(SYM_W), .COMMA_W(COMMA_W),
    .PLUS_PAT(PLUS_PAT), .MINUS_PAT(MINUS_PAT)
  ) u_scan (
    .win(win[SCAN_W-1:0]), .plus_hit(plus_hit), .minus_hit(minus_hit)
  );

  cad_offset_ctl #(
    .SYM_W(SYM_W), .LOCK_ON_PLUS(LOCK_ON_PLUS), .LOCK_ON_MINUS(LOCK_ON_MINUS)
  ) u_ctl (
    .clk(clk), .rst(rst), .use_align(use_align),
    .plus_en(plus_align_en), .minus_en(minus_align_en),
    .plus_hit(plus_hit), .minus_hit(minus_hit),
    .off_q(off_q), .en_hit_any(en_hit_any),
    .comma_seen(comma_seen), .realigned(realigned), .locked(locked)
  );

  cad_shift #(.SYM_W(SYM_W)) u_shift (
    .clk(clk), .rst(rst), .use_align(use_align), .rx_word(rx_word),
    .win(win), .off_q(off_q), .aligned_word(aligned_word)
  );
endmodule

// File: rtl/cad_chk.sv
module cad_chk #(
  parameter int unsigned SYM_W = 10,
  parameter int unsigned OFF_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             use_align,
  input logic             plus_align_en,
  input logic             minus_align_en,
  input logic [SYM_W-1:0] plus_hit,
  input logic [SYM_W-1:0] minus_hit,
  input logic [OFF_W-1:0] off_q,
  input logic             en_hit_any,
  input logic             comma_seen,
  input logic             realigned,
  input logic             locked
);
  // R3
  plus_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((|plus_hit) && !(|minus_hit) && !plus_align_en) |=> (!realigned && $stable(off_q)));

  // R4
  minus_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((|minus_hit) && !(|plus_hit) && !minus_align_en) |=> (!realigned && $stable(off_q)));

  // R5
  pulse_moves_chk: assert property (@(posedge clk) disable iff (rst)
    realigned |-> (off_q != $past(off_q)));

  // R5
  move_pulses_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (off_q != $past(off_q))) |-> realigned);

  // R6
  move_cause_chk: assert property (@(posedge clk) disable iff (rst)
    realigned |-> $past(en_hit_any));

  // R8
  bypass_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    !use_align |=> !locked);

  // R9
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !use_align |=> (!comma_seen && !realigned && $stable(off_q)));

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (off_q == '0 && !comma_seen && !realigned && !locked));
endmodule

bind comma_aligner cad_chk #(.SYM_W(SYM_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .use_align(use_align),
  .plus_align_en(plus_align_en), .minus_align_en(minus_align_en),
  .plus_hit(plus_hit), .minus_hit(minus_hit), .off_q(off_q),
  .en_hit_any(en_hit_any), .comma_seen(comma_seen),
  .realigned(realigned), .locked(locked)
);

// File: tb/comma_aligner_tb.sv
module comma_aligner_tb;
  localparam logic [9:0] FILL   = 10'b1010101010;
  localparam logic [9:0] PLUS_S = 10'b0101111100;
  localparam logic [9:0] MIN_S  = 10'b1010000011;
  localparam int NV = 12;
  // {offset[3:0], plus(1)/minus(0), plus_en, minus_en, expected realign}
  localparam logic [7:0] VEC [NV] = '{
    8'h4A, 8'h3F, 8'h36, 8'h74, 8'h77, 8'h0A,
    8'h0D, 8'h97, 8'h5F, 8'h98, 8'h13, 8'h1E
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] rx_word = FILL;
  logic       use_align = 1'b1, plus_align_en = 1'b1, minus_align_en = 1'b1;
  logic [9:0] aligned_word;
  logic       comma_seen, realigned, locked;
  logic       cfg_use = 1'b1, cfg_p = 1'b1, cfg_m = 1'b1;

  int n_chk = 0, n_bad = 0;
  int model_off = 0;
  bit model_lock = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  comma_aligner u_dut (
    .clk(clk), .rst(rst), .rx_word(rx_word), .use_align(use_align),
    .plus_align_en(plus_align_en), .minus_align_en(minus_align_en),
    .aligned_word(aligned_word), .comma_seen(comma_seen),
    .realigned(realigned), .locked(locked)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive a word at the falling edge, then sample just after the rising edge
  task automatic push(input logic [9:0] w);
    @(negedge clk);
    rx_word = w; use_align = cfg_use;
    plus_align_en = cfg_p; minus_align_en = cfg_m;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [19:0] build(input int k, input bit plus);
    logic [19:0] w;
    w = {FILL, FILL};
    w[k +: 10] = plus ? PLUS_S : MIN_S;
    return w;
  endfunction

  // sends window w; returns after the edge that captures it
  task automatic send(input logic [19:0] w);
    push(FILL);
    push(w[9:0]);
    push(w[19:10]);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [19:0] w;
    push(FILL); push(FILL);
    // R10 reset state
    chk("R10 aligned_word", aligned_word, 0);
    chk("R10 comma_seen", comma_seen, 0);
    chk("R10 realigned", realigned, 0);
    chk("R10 locked", locked, 0);
    rst = 1'b0;
    push(FILL); push(FILL); push(FILL);
    chk("R1 no comma in filler", comma_seen, 0);

    for (int v = 0; v < NV; v++) begin
      int  k;
      bit  pol, en, exp_rl;
      k = int'(VEC[v][7:4]); pol = VEC[v][3];
      cfg_p = VEC[v][2]; cfg_m = VEC[v][1]; exp_rl = VEC[v][0];
      en = pol ? cfg_p : cfg_m;
      if (en) begin
        model_off = k;
        model_lock = 1'b1;
      end
      w = build(k, pol);
      send(w);
      chk(pol ? "R1 plus detect" : "R2 minus detect", comma_seen, 1);
      chk(pol ? "R3 plus realign" : "R4 minus realign", realigned, exp_rl);
      chk("R8 locked", locked, model_lock);
      push(FILL);
      chk("R5 one-cycle pulse", realigned, 0);
      chk("R1 detect clears", comma_seen, 0);
      push(FILL);
      chk("R7 aligned data", aligned_word, w[model_off +: 10]);
    end

    // R6: plus at 0 and minus at 8 in one window, from offset 5
    cfg_p = 1'b1; cfg_m = 1'b1;
    send(build(5, 1'b1));
    chk("R5 move to 5", realigned, 1);
    push(FILL); push(FILL);
    w = {5'b10101, 5'b00000, 2'b11, 1'b0, 7'b1111100};
    send(w);
    chk("R6 realign on dual", realigned, 1);
    push(FILL); push(FILL);
    chk("R6 lowest offset chosen", aligned_word, w[9:0]);

    // R9 bypass
    cfg_use = 1'b0;
    push(10'h2C5);
    chk("R9 bypass data", aligned_word, 10'h2C5);
    chk("R8 unlock in bypass", locked, 0);
    push(10'h13A);
    chk("R9 bypass data 2", aligned_word, 10'h13A);
    w = build(6, 1'b1);
    send(w);
    chk("R9 no detect in bypass", comma_seen, 0);
    chk("R9 no realign in bypass", realigned, 0);
    chk("R9 bypass comma word", aligned_word, w[19:10]);
    cfg_use = 1'b1;
    push(FILL); push(FILL);
    send(build(0, 1'b1));
    chk("R9 offset held across bypass", realigned, 0);
    chk("R8 relock", locked, 1);

    // R10 mid-run reset clears the offset
    send(build(4, 1'b1));
    chk("R5 move to 4", realigned, 1);
    rst = 1'b1;
    push(FILL); push(FILL);
    chk("R10 locked after reset", locked, 0);
    chk("R10 data after reset", aligned_word, 0);
    rst = 1'b0;
    push(FILL);
    send(build(0, 1'b1));
    chk("R10 offset cleared to 0", realigned, 0);
    chk("R8 lock after reset", locked, 1);

    finish_run();
  end
endmodule